// File: doc/BRIEF.md
# RTC register reset controller

This block governs the internal reset of a sixteen-register real-time-clock bank that is reached through a serial two-wire bus slave. There is no supply-ramp reset in the usual sense. The internal reset is held for as long as the crystal oscillator reports that it is stopped.

While reset is held, the block refuses bus traffic, keeps the register address pointer at zero and forces a defined pattern into the reset-sensitive bits of the bank. Bits without a defined reset value keep whatever they held before.

Crystals can take a long time to start, so a test override is provided to end reset early. The override is recognised from a toggle pattern on the filtered bus lines. It is allowed only while the test-enable bit (bit 3 of register 0) is 1. Writing that bit to 0 cancels the override.

The bus protocol engine and the time counters live elsewhere. They see this block through its write port, its pointer-load port, the bus-enable flag and the flattened bank contents.

Top module: `rtc_rst_ctrl`

## Requirements
- R1: `rstActive` is 1 whenever `oscRun` is 0 and the override is off, and `rstActive` is 0 whenever `oscRun` is 1.
- R2: While `rstActive` is 1, the following hold:
  - `busEn` is 0.
  - `addrPtr` reads 0 from the next cycle on.
  - Register writes and pointer loads change nothing.
- R3: One cycle of reset loads register 0 with 08h and register 1 with 00h. This leaves the test-enable bit (register 0 bit 3) at 1.
- R4: One cycle of reset sets bit 7 of register 2 and of registers 9 to 12, and leaves their other bits unchanged.
- R5: One cycle of reset gives register 13 bit 7 = 1 and bits 1:0 = 00, and gives register 14 bit 7 = 0 and bits 1:0 = 11. All other bits of both registers are unchanged.
- R6: Registers 3 to 8 and register 15 are not altered by reset.
- R7: The override pattern consists of two parts:
  - First, four SDA falling edges while SCL is low (SDA may rise between them while SCL is low).
  - Then, SCL rises and falls.
  - Every edge of either line must come at least MIN_GAP clock cycles after the previous edge.
  - On the SCL fall, if the test-enable bit is 1, `overrideOn` becomes 1 and reset ends in the next cycle with `busEn` = 1.
- R8: Any of the following restarts pattern detection without entering override:
  - an edge fewer than MIN_GAP cycles after the previous edge;
  - an SDA edge while SCL is high;
  - an SCL rise before four SDA falls.
- R9: Writing the test-enable bit to 0 clears `overrideOn`. With the oscillator stopped, reset then resumes and register 0 is reloaded with 08h.
- R10: While the test-enable bit is 0, a complete override pattern leaves `overrideOn` at 0. Clearing the bit with the oscillator running keeps `rstActive` at 0 and `busEn` at 1, and leaves the other registers as they were.
- R11: Outside reset, the following hold:
  - `wrEn` stores `wrData` into register `wrAddr`, visible in the next cycle.
  - `ptrLoad` sets `addrPtr` to `ptrData` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-up clear, active low |
| oscRun | input | 1 | Oscillator running flag |
| sdaIn | input | 1 | Filtered SDA level |
| sclIn | input | 1 | Filtered SCL level |
| wrEn | input | 1 | Register write request |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| ptrLoad | input | 1 | Address pointer load request |
| ptrData | input | 4 | Address pointer load value |
| rstActive | output | 1 | Internal reset is held |
| busEn | output | 1 | Bus transactions accepted |
| overrideOn | output | 1 | Test override is in force |
| addrPtr | output | 4 | Register address pointer |
| regFlat | output | 128 | Bank contents, register n in bits 8n+7:8n |

## Verification
The bench sweeps every register through several data patterns and then applies one reset cycle. A wrong mask shows up in one of three ways: a defined bit not being forced, a neighbouring bit being wiped, or a register with no reset value being cleared.

The override pattern is replayed with exactly one edge shortened to MIN_GAP-1 cycles, once for each edge position. It is also replayed with every edge short, and with an SDA edge during the SCL high phase. A detector that skips the spacing check, or that fails to restart, would enter override on one of these replays.

The test-enable path is exercised in both states. A design that latched the override past a cleared bit, or that failed to reload 08h, would stay out of reset. A design that gated entry on something other than the bit would enter override with the oscillator running.

// File: rtl/rtc_rst_pkg.sv
package rtc_rst_pkg;

  localparam int REG_W   = 8;
  localparam int REG_N   = 16;
  localparam int ADDR_W  = $clog2(REG_N);
  localparam int FLAT_W  = REG_W * REG_N;
  localparam int TESTC_BIT = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadDefaults;
    logic acceptWr;
    logic acceptPtr;
  } ctlStrobe_t;

  // Bits forced to 1 by reset.
  function automatic logic [REG_W-1:0] rstSetMask(input int idx);
    case (idx)
      0:                 return 8'h08;
      2, 9, 10, 11, 12:  return 8'h80;
      13:                return 8'h80;
      14:                return 8'h03;
      default:           return 8'h00;
    endcase
  endfunction

  // Bits forced to 0 by reset (applied before the set mask).
  function automatic logic [REG_W-1:0] rstClrMask(input int idx);
    case (idx)
      0, 1:    return 8'hFF;
      13:      return 8'h03;
      14:      return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_rst_seq_det.sv
module rtc_rst_seq_det #(
  parameter int MIN_GAP = 8,
  parameter int NFALL   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdaIn,
  input  logic sclIn,
  output logic seqHit
);

  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam int CNT_W = $clog2(NFALL + 1);

  logic             sdaQ, sclQ;
  logic [GAP_W-1:0] gapCnt;
  logic [CNT_W-1:0] fallCnt, fallNext;
  logic             armed, armedNext;
  logic             sdaEdge, sclEdge, anyEdge, gapOk;

  assign sdaEdge = sdaQ ^ sdaIn;
  assign sclEdge = sclQ ^ sclIn;
  assign anyEdge = sdaEdge | sclEdge;
  assign gapOk   = (gapCnt >= GAP_W'(MIN_GAP));

  always_comb begin
    fallNext  = fallCnt;
    armedNext = armed;
    seqHit    = 1'b0;
    if (anyEdge) begin
      if (!gapOk || (sdaEdge && sclEdge)) begin
        fallNext  = '0;
        armedNext = 1'b0;
      end else if (sdaEdge) begin
        if (sclQ) begin
          fallNext  = '0;
          armedNext = 1'b0;
        end else if (!sdaIn) begin
          if (fallCnt == CNT_W'(NFALL)) begin
            fallNext = '0;
          end else begin
            fallNext = fallCnt + CNT_W'(1);
          end
        end
      end else if (sclIn) begin
        if (fallCnt == CNT_W'(NFALL)) begin
          armedNext = 1'b1;
          fallNext  = '0;
        end else begin
          fallNext  = '0;
          armedNext = 1'b0;
        end
      end else if (armed) begin
        seqHit    = 1'b1;
        armedNext = 1'b0;
        fallNext  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdaQ    <= 1'b1;
      sclQ    <= 1'b1;
      gapCnt  <= GAP_W'(MIN_GAP);
      fallCnt <= '0;
      armed   <= 1'b0;
    end else begin
      sdaQ    <= sdaIn;
      sclQ    <= sclIn;
      fallCnt <= fallNext;
      armed   <= armedNext;
      if (anyEdge) begin
        gapCnt <= GAP_W'(1);
      end else if (!gapOk) begin
        gapCnt <= gapCnt + GAP_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_rst_ctl.sv
module rtc_rst_ctl
  import rtc_rst_pkg::*;
#(
  parameter int MIN_GAP = 8,
  parameter int NFALL   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oscRun,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  logic       testcBit,
  input  logic       wrReq,
  input  logic       ptrReq,
  output ctlStrobe_t strobe,
  output logic       rstActive,
  output logic       busEn,
  output logic       overrideOn
);

  logic seqHit;
  logic overrideQ;

  rtc_rst_seq_det #(
    .MIN_GAP(MIN_GAP),
    .NFALL  (NFALL)
  ) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .sdaIn (sdaIn),
    .sclIn (sclIn),
    .seqHit(seqHit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrideQ <= 1'b0;
    end else if (overrideQ) begin
      overrideQ <= testcBit;
    end else begin
      overrideQ <= seqHit & testcBit;
    end
  end

  assign rstActive  = ~oscRun & ~overrideQ;
  assign busEn      = ~rstActive;
  assign overrideOn = overrideQ;

  always_comb begin
    strobe.loadDefaults = rstActive;
    strobe.acceptWr     = wrReq & busEn;
    strobe.acceptPtr    = ptrReq & busEn;
  end

endmodule

// File: rtl/rtc_rst_dp.sv
module rtc_rst_dp
  import rtc_rst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] ptrData,
  output logic [FLAT_W-1:0] regFlat,
  output logic [ADDR_W-1:0] addrPtr,
  output logic              testcBit
);

  logic [REG_W-1:0] bankQ [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    localparam logic [REG_W-1:0] SET_M = rstSetMask(i);
    localparam logic [REG_W-1:0] CLR_M = rstClrMask(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bankQ[i] <= SET_M;
      end else if (strobe.loadDefaults) begin
        bankQ[i] <= (bankQ[i] & ~CLR_M) | SET_M;
      end else if (strobe.acceptWr && (wrAddr == ADDR_W'(i))) begin
        bankQ[i] <= wrData;
      end
    end

    assign regFlat[i*REG_W +: REG_W] = bankQ[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrPtr <= '0;
    end else if (strobe.loadDefaults) begin
      addrPtr <= '0;
    end else if (strobe.acceptPtr) begin
      addrPtr <= ptrData;
    end
  end

  assign testcBit = bankQ[0][TESTC_BIT];

endmodule

// File: rtl/rtc_rst_ctrl.sv
module rtc_rst_ctrl
  import rtc_rst_pkg::*;
#(
  parameter int MIN_GAP = 8,
  parameter int NFALL   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oscRun,
  input  logic         sdaIn,
  input  logic         sclIn,
  input  logic         wrEn,
  input  logic [3:0]   wrAddr,
  input  logic [7:0]   wrData,
  input  logic         ptrLoad,
  input  logic [3:0]   ptrData,
  output logic         rstActive,
  output logic         busEn,
  output logic         overrideOn,
  output logic [3:0]   addrPtr,
  output logic [127:0] regFlat
);

  ctlStrobe_t strobe;
  logic       testcBit;

  rtc_rst_ctl #(
    .MIN_GAP(MIN_GAP),
    .NFALL  (NFALL)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .oscRun    (oscRun),
    .sdaIn     (sdaIn),
    .sclIn     (sclIn),
    .testcBit  (testcBit),
    .wrReq     (wrEn),
    .ptrReq    (ptrLoad),
    .strobe    (strobe),
    .rstActive (rstActive),
    .busEn     (busEn),
    .overrideOn(overrideOn)
  );

  rtc_rst_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .ptrData (ptrData),
    .regFlat (regFlat),
    .addrPtr (addrPtr),
    .testcBit(testcBit)
  );

endmodule

// File: rtl/rtc_rst_ctrl_chk.sv
module rtc_rst_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         oscRun,
  input logic         wrEn,
  input logic [3:0]   wrAddr,
  input logic         rstActive,
  input logic         busEn,
  input logic         overrideOn,
  input logic [3:0]   addrPtr,
  input logic [127:0] regFlat
);

  AST_OSC_RUN_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    oscRun |-> !rstActive); // R1

  AST_BUS_OFF_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |-> !busEn); // R2

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |=> (addrPtr == 4'd0)); // R2

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rstActive && wrEn && wrAddr == 4'd15) |=> $stable(regFlat[127:120])); // R2

  AST_CTRL_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |=> (regFlat[15:0] == 16'h0008)); // R3

  AST_SEC_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |=> regFlat[23]); // R4

  AST_TIMER_CTRL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |=> (!regFlat[119] && regFlat[113:112] == 2'b11)); // R5

  AST_OVR_NEEDS_TESTC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrideOn) |-> $past(regFlat[3])); // R7

  AST_OVR_DROPS_TESTC: assert property (@(posedge clk) disable iff (!rst_n)
    (overrideOn && !regFlat[3]) |=> !overrideOn); // R9

endmodule

bind rtc_rst_ctrl rtc_rst_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oscRun    (oscRun),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .rstActive (rstActive),
  .busEn     (busEn),
  .overrideOn(overrideOn),
  .addrPtr   (addrPtr),
  .regFlat   (regFlat)
);

// File: tb/rtc_rst_ctrl_bench.sv
module rtc_rst_ctrl_bench;

  localparam int MIN_GAP = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         oscRun;
  logic         sdaIn;
  logic         sclIn;
  logic         wrEn;
  logic [3:0]   wrAddr;
  logic [7:0]   wrData;
  logic         ptrLoad;
  logic [3:0]   ptrData;
  logic         rstActive;
  logic         busEn;
  logic         overrideOn;
  logic [3:0]   addrPtr;
  logic [127:0] regFlat;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rtc_rst_ctrl #(.MIN_GAP(MIN_GAP), .NFALL(4)) u_rtc_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .oscRun(oscRun), .sdaIn(sdaIn), .sclIn(sclIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ptrLoad(ptrLoad),
    .ptrData(ptrData), .rstActive(rstActive), .busEn(busEn),
    .overrideOn(overrideOn), .addrPtr(addrPtr), .regFlat(regFlat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] regAt(input int a);
    return regFlat[a*8 +: 8];
  endfunction

  // Expected content after one reset cycle, from R3..R6.
  function automatic logic [7:0] expRst(input int a, input logic [7:0] v);
    case (a)
      0:                return 8'h08;
      1:                return 8'h00;
      2, 9, 10, 11, 12: return v | 8'h80;
      13:               return (v | 8'h80) & 8'hFC;
      14:               return (v & 8'h7F) | 8'h03;
      default:          return v;
    endcase
  endfunction

  function automatic string tagFor(input int a);
    if (a <= 1) return "R3";
    if (a == 2 || (a >= 9 && a <= 12)) return "R4";
    if (a == 13 || a == 14) return "R5";
    return "R6";
  endfunction

  task automatic wrReg(input int a, input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic step(input int waitCyc, input bit s, input bit c);
    repeat (waitCyc) @(negedge clk);
    sdaIn = s; sclIn = c;
  endtask

  function automatic int gapFor(input int idx, input int shortIdx, input int gapAll);
    return (idx == shortIdx) ? MIN_GAP - 1 : gapAll;
  endfunction

  // Override pattern; edge shortIdx is one cycle short, badHigh adds an
  // SDA edge during the SCL high phase. Ends one cycle after the last edge.
  task automatic seq(input int shortIdx, input int gapAll, input bit badHigh);
    repeat (MIN_GAP + 2) @(negedge clk);
    step(0, 1'b1, 1'b0);
    for (int k = 1; k <= 7; k++) begin
      step(gapFor(k, shortIdx, gapAll), (k % 2) == 0, 1'b0);
    end
    step(gapFor(8, shortIdx, gapAll), 1'b0, 1'b1);
    if (badHigh) step(gapAll, 1'b1, 1'b1);
    step(gapFor(9, shortIdx, gapAll), sdaIn, 1'b0);
    @(negedge clk);
  endtask

  task automatic toIdle();
    if (!sdaIn) step(MIN_GAP, 1'b1, sclIn);
    step(MIN_GAP, 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; oscRun = 1'b0; sdaIn = 1'b1; sclIn = 1'b1;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; ptrLoad = 1'b0; ptrData = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset held while stopped", 32'(rstActive), 1);
    chk("R2 bus refused", 32'(busEn), 0);
    chk("R2 pointer zero", 32'(addrPtr), 0);
    chk("R3 control 0", 32'(regAt(0)), 32'h08);
    chk("R3 control 1", 32'(regAt(1)), 32'h00);

    oscRun = 1'b1;
    @(negedge clk);
    chk("R1 running releases reset", 32'(rstActive), 0);
    chk("R1 bus enabled", 32'(busEn), 1);

    // Sweep patterns over the whole bank, then one reset cycle.
    for (int p = 0; p < 5; p++) begin
      logic [7:0] base;
      logic [7:0] vals [16];
      base = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : (p == 3) ? 8'h5A : 8'h3C;
      for (int a = 0; a < 16; a++) begin
        vals[a] = base ^ 8'(a * 17);
        wrReg(a, vals[a]);
        chk("R11 write lands", 32'(regAt(a)), 32'(vals[a]));
      end
      @(negedge clk);
      ptrLoad = 1'b1; ptrData = 4'(p + 7);
      @(negedge clk);
      ptrLoad = 1'b0;
      chk("R11 pointer load", 32'(addrPtr), 32'(p + 7));
      oscRun = 1'b0;
      @(negedge clk);
      chk("R2 pointer cleared", 32'(addrPtr), 0);
      for (int a = 0; a < 16; a++) begin
        chk(tagFor(a), 32'(regAt(a)), 32'(expRst(a, vals[a])));
      end
      wrEn = 1'b1; wrAddr = 4'd15; wrData = ~vals[15];
      ptrLoad = 1'b1; ptrData = 4'd9;
      @(negedge clk);
      wrEn = 1'b0; ptrLoad = 1'b0;
      @(negedge clk);
      chk("R2 write ignored in reset", 32'(regAt(15)), 32'(vals[15]));
      chk("R2 pointer load ignored", 32'(addrPtr), 0);
      oscRun = 1'b1;
      @(negedge clk);
    end

    // Override entry with the oscillator stopped.
    oscRun = 1'b0;
    @(negedge clk);
    seq(-1, MIN_GAP, 1'b0);
    chk("R7 override entered", 32'(overrideOn), 1);
    chk("R7 reset ended", 32'(rstActive), 0);
    chk("R7 bus enabled", 32'(busEn), 1);
    toIdle();
    wrReg(15, 8'hC3);
    chk("R11 write under override", 32'(regAt(15)), 32'hC3);
    wrReg(0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 override cleared", 32'(overrideOn), 0);
    chk("R9 reset resumes", 32'(rstActive), 1);
    chk("R9 control 0 reloaded", 32'(regAt(0)), 32'h08);

    // One short edge at each position.
    for (int s = 1; s <= 9; s++) begin
      seq(s, MIN_GAP, 1'b0);
      chk("R8 short edge restarts", 32'(overrideOn), 0);
      chk("R8 reset still held", 32'(rstActive), 1);
      toIdle();
    end
    seq(-1, MIN_GAP - 1, 1'b0);
    chk("R8 all edges short", 32'(overrideOn), 0);
    toIdle();
    seq(-1, MIN_GAP, 1'b1);
    chk("R8 SDA edge while SCL high", 32'(overrideOn), 0);
    toIdle();

    // Test-enable cleared while running.
    seq(-1, MIN_GAP, 1'b0);
    chk("R7 override re-entered", 32'(overrideOn), 1);
    toIdle();
    oscRun = 1'b1;
    wrReg(0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10 override dropped", 32'(overrideOn), 0);
    chk("R10 no reset while running", 32'(rstActive), 0);
    chk("R10 bus still enabled", 32'(busEn), 1);
    seq(-1, MIN_GAP, 1'b0);
    chk("R10 entry blocked", 32'(overrideOn), 0);
    chk("R10 test-enable stays 0", 32'(regAt(0)), 32'h00);
    chk("R10 other register kept", 32'(regAt(15)), 32'hC3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule